// File: doc/BRIEF.md
# AXI4 Address-Channel User Sideband Stripper

This block sits between an AXI4 master whose AW and AR channels carry a user sideband and a slave that has no user signals at all. Each address request that the block accepts has its user value stored, and the request then goes downstream without it. When the matching B or R response returns, the block reattaches that stored value. The slave never has to carry the sideband, and the master still sees it on every response.

The stored values live in small FIFO queues. There is one queue per transaction ID for writes and a separate queue per ID for reads. Responses that share an ID come back in request order, so a response always takes the value at the head of its ID's queue. Responses with different IDs may return in any order. When an ID's queue is full, only new requests for that ID are held back; other IDs keep flowing. The per-ID depth is set by `FLIGHT_CAP`. A cap of 0 selects the largest depth the block is built for, which is `MAX_DEPTH`.

W beats, and the data and status fields of the B and R channels, go straight through.

Top module: `axi_user_strip`

## Requirements
- R1: After reset no request is outstanding. With no request offered, `m_aw_valid` and `m_ar_valid` are 0, and `s_aw_ready`/`s_ar_ready` follow `m_aw_ready`/`m_ar_ready`.
- R2: An AW (or AR) request goes downstream in the same cycle with its ID and address unchanged. It is accepted upstream exactly when it is accepted downstream.
- R3: Every B response carries on `s_b_user` the user value of the oldest write still outstanding with the same ID. This holds whatever order the IDs return in.
- R4: Every beat of an R burst carries on `s_r_user` the user value of the oldest read still outstanding with the same ID. Bursts of different IDs may interleave beat by beat.
- R5: A read queue entry is released only by a handshaked R beat with `last` = 1. Beats with `last` = 0 leave the stored value in place for the later beats of the burst.
- R6: While `FLIGHT_CAP` requests of one ID are outstanding on a side, a new request of that ID on that side sees ready = 0, and no valid is sent downstream. Requests of other IDs are still accepted.
- R7: A B handshake, or a last-beat R handshake, frees one entry of its ID in the cycle after it. A B or R beat held by upstream ready = 0 frees nothing.
- R8: `w` data/last/valid/ready, B `id`/`resp`/valid/ready and R `id`/`data`/`resp`/`last`/valid/ready pass through unchanged.
- R9: The read and write sides are independent. A full write queue for an ID does not stall reads of that ID.
- R10: With `FLIGHT_CAP` = 0 each ID holds `MAX_DEPTH` outstanding requests per side before it stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_aw_valid | input | 1 | Upstream write request valid |
| s_aw_ready | output | 1 | Upstream write request ready |
| s_aw_id | input | ID_W | Upstream write ID |
| s_aw_addr | input | ADDR_W | Upstream write address |
| s_aw_user | input | USER_W | Upstream write user sideband |
| m_aw_valid | output | 1 | Downstream write request valid |
| m_aw_ready | input | 1 | Downstream write request ready |
| m_aw_id | output | ID_W | Downstream write ID |
| m_aw_addr | output | ADDR_W | Downstream write address |
| s_w_valid | input | 1 | Upstream write data valid |
| s_w_ready | output | 1 | Upstream write data ready |
| s_w_data | input | DATA_W | Upstream write data |
| s_w_last | input | 1 | Upstream last write beat |
| m_w_valid | output | 1 | Downstream write data valid |
| m_w_ready | input | 1 | Downstream write data ready |
| m_w_data | output | DATA_W | Downstream write data |
| m_w_last | output | 1 | Downstream last write beat |
| m_b_valid | input | 1 | Downstream write response valid |
| m_b_ready | output | 1 | Downstream write response ready |
| m_b_id | input | ID_W | Downstream write response ID |
| m_b_resp | input | 2 | Downstream write response status |
| s_b_valid | output | 1 | Upstream write response valid |
| s_b_ready | input | 1 | Upstream write response ready |
| s_b_id | output | ID_W | Upstream write response ID |
| s_b_resp | output | 2 | Upstream write response status |
| s_b_user | output | USER_W | Restored write user value |
| s_ar_valid | input | 1 | Upstream read request valid |
| s_ar_ready | output | 1 | Upstream read request ready |
| s_ar_id | input | ID_W | Upstream read ID |
| s_ar_addr | input | ADDR_W | Upstream read address |
| s_ar_user | input | USER_W | Upstream read user sideband |
| m_ar_valid | output | 1 | Downstream read request valid |
| m_ar_ready | input | 1 | Downstream read request ready |
| m_ar_id | output | ID_W | Downstream read ID |
| m_ar_addr | output | ADDR_W | Downstream read address |
| m_r_valid | input | 1 | Downstream read beat valid |
| m_r_ready | output | 1 | Downstream read beat ready |
| m_r_id | input | ID_W | Downstream read beat ID |
| m_r_data | input | DATA_W | Downstream read data |
| m_r_resp | input | 2 | Downstream read status |
| m_r_last | input | 1 | Downstream last read beat |
| s_r_valid | output | 1 | Upstream read beat valid |
| s_r_ready | input | 1 | Upstream read beat ready |
| s_r_id | output | ID_W | Upstream read beat ID |
| s_r_data | output | DATA_W | Upstream read data |
| s_r_resp | output | 2 | Upstream read status |
| s_r_last | output | 1 | Upstream last read beat |
| s_r_user | output | USER_W | Restored read user value |

## Verification
The hardest case to reach is the one where every queue is full, on both sides at once, while responses come back in an order unrelated to the request order. In that state, a wrong head pointer or a cross-ID mix-up shows up as a wrong user value.

To get there, the bench sweeps every ID twice on the write side, then twice on the read side. Next it offers one more request per ID and expects each to stall. It then returns B responses in a permuted ID order. R bursts follow, interleaved beat by beat across IDs, so that non-last beats sit between the bursts of other IDs.

A second instance with the cap left at 0 receives the same stimulus. That instance must accept the extra requests and stall only one request later.

// File: rtl/axi_user_strip_pkg.sv
// Shared helpers for the user sideband stripper.
// Assumes: callers pass a non-negative cap and a positive maximum depth.
package axi_user_strip_pkg;

    // Resolve the per-ID queue depth: a cap of 0 means the largest supported depth.
    function automatic int flight_depth(input int cap, input int max_depth);
        return (cap == 0) ? max_depth : cap;
    endfunction

endpackage

// File: rtl/user_fifo.sv
// Small FIFO that holds user values for one transaction ID.
// Assumes: push is never asked while full and pop never while empty
// (both are guarded here anyway); head is meaningful only when not empty.
module user_fifo #(
    parameter int DEPTH  = 2,
    parameter int USER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [USER_W-1:0] push_user,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [USER_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [USER_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify the requests against occupancy.
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Store the pushed value at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_user;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];
endmodule

// File: rtl/user_track.sv
// Set of per-ID user FIFOs for one direction (read or write).
// Assumes: responses of one ID return in the order their requests were accepted.
module user_track #(
    parameter int ID_W   = 2,
    parameter int USER_W = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [USER_W-1:0] push_user,
    input  logic              pop,
    input  logic [ID_W-1:0]   pop_id,
    output logic              push_full,
    output logic [USER_W-1:0] pop_head
);
    localparam int NUM_ID = 1 << ID_W;

    logic [NUM_ID-1:0] full_v;
    logic [NUM_ID-1:0] empty_v;
    logic [USER_W-1:0] head_v [NUM_ID];

    // One queue per ID value.
    for (genvar g = 0; g < NUM_ID; g++) begin : g_q
        user_fifo #(
            .DEPTH  (DEPTH),
            .USER_W (USER_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push && (push_id == ID_W'(g))),
            .push_user (push_user),
            .pop       (pop && (pop_id == ID_W'(g))),
            .full      (full_v[g]),
            .empty     (empty_v[g]),
            .head      (head_v[g])
        );
    end

    assign push_full = full_v[push_id];
    assign pop_head  = head_v[pop_id];
endmodule

// File: rtl/axi_user_strip.sv
// Removes the user sideband from the AW/AR channels and restores it on B/R.
// Assumes: same-ID responses return in request order; every response matches
// an outstanding request; R bursts end with last = 1.
module axi_user_strip #(
    parameter int ID_W       = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int USER_W     = 4,
    parameter int FLIGHT_CAP = 2,
    parameter int MAX_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [USER_W-1:0] s_aw_user,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ID_W-1:0]   m_aw_id,
    output logic [ADDR_W-1:0] m_aw_addr,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic              s_w_last,
    output logic              m_w_valid,
    input  logic              m_w_ready,
    output logic [DATA_W-1:0] m_w_data,
    output logic              m_w_last,
    input  logic              m_b_valid,
    output logic              m_b_ready,
    input  logic [ID_W-1:0]   m_b_id,
    input  logic [1:0]        m_b_resp,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [ID_W-1:0]   s_b_id,
    output logic [1:0]        s_b_resp,
    output logic [USER_W-1:0] s_b_user,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [USER_W-1:0] s_ar_user,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ID_W-1:0]   m_ar_id,
    output logic [ADDR_W-1:0] m_ar_addr,
    input  logic              m_r_valid,
    output logic              m_r_ready,
    input  logic [ID_W-1:0]   m_r_id,
    input  logic [DATA_W-1:0] m_r_data,
    input  logic [1:0]        m_r_resp,
    input  logic              m_r_last,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [ID_W-1:0]   s_r_id,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic              s_r_last,
    output logic [USER_W-1:0] s_r_user
);
    localparam int DEPTH = axi_user_strip_pkg::flight_depth(FLIGHT_CAP, MAX_DEPTH);

    logic aw_full;
    logic ar_full;
    logic aw_take;
    logic ar_take;
    logic b_done;
    logic r_done;

    // Write side: gate the request on its ID's queue space.
    assign m_aw_valid = s_aw_valid && !aw_full;
    assign s_aw_ready = m_aw_ready && !aw_full;
    assign m_aw_id    = s_aw_id;
    assign m_aw_addr  = s_aw_addr;
    assign aw_take    = s_aw_valid && s_aw_ready;

    // Read side: same gating with its own queues.
    assign m_ar_valid = s_ar_valid && !ar_full;
    assign s_ar_ready = m_ar_ready && !ar_full;
    assign m_ar_id    = s_ar_id;
    assign m_ar_addr  = s_ar_addr;
    assign ar_take    = s_ar_valid && s_ar_ready;

    // Write data is untouched.
    assign m_w_valid = s_w_valid;
    assign s_w_ready = m_w_ready;
    assign m_w_data  = s_w_data;
    assign m_w_last  = s_w_last;

    // Write responses: pass through, release on handshake.
    assign s_b_valid = m_b_valid;
    assign m_b_ready = s_b_ready;
    assign s_b_id    = m_b_id;
    assign s_b_resp  = m_b_resp;
    assign b_done    = m_b_valid && s_b_ready;

    // Read beats: pass through, release on the closing beat.
    assign s_r_valid = m_r_valid;
    assign m_r_ready = s_r_ready;
    assign s_r_id    = m_r_id;
    assign s_r_data  = m_r_data;
    assign s_r_resp  = m_r_resp;
    assign s_r_last  = m_r_last;
    assign r_done    = m_r_valid && s_r_ready && m_r_last;

    user_track #(
        .ID_W   (ID_W),
        .USER_W (USER_W),
        .DEPTH  (DEPTH)
    ) u_wr_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (aw_take),
        .push_id   (s_aw_id),
        .push_user (s_aw_user),
        .pop       (b_done),
        .pop_id    (m_b_id),
        .push_full (aw_full),
        .pop_head  (s_b_user)
    );

    user_track #(
        .ID_W   (ID_W),
        .USER_W (USER_W),
        .DEPTH  (DEPTH)
    ) u_rd_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ar_take),
        .push_id   (s_ar_id),
        .push_user (s_ar_user),
        .pop       (r_done),
        .pop_id    (m_r_id),
        .push_full (ar_full),
        .pop_head  (s_r_user)
    );
endmodule

// File: rtl/axi_user_strip_chk.sv
// Port-level checker for the user sideband stripper; counts outstanding
// requests per ID from the handshakes alone.
// Assumes: the environment never returns a response without a request.
module axi_user_strip_chk #(
    parameter int ID_W       = 2,
    parameter int FLIGHT_CAP = 2,
    parameter int MAX_DEPTH  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_aw_valid,
    input logic            s_aw_ready,
    input logic [ID_W-1:0] s_aw_id,
    input logic            m_aw_valid,
    input logic            m_aw_ready,
    input logic            s_ar_valid,
    input logic            s_ar_ready,
    input logic [ID_W-1:0] s_ar_id,
    input logic            m_ar_valid,
    input logic            m_ar_ready,
    input logic            m_b_valid,
    input logic            s_b_ready,
    input logic [ID_W-1:0] m_b_id,
    input logic            m_r_valid,
    input logic            s_r_ready,
    input logic            m_r_last,
    input logic [ID_W-1:0] m_r_id
);
    localparam int NUM_ID = 1 << ID_W;
    localparam int DEPTH  = axi_user_strip_pkg::flight_depth(FLIGHT_CAP, MAX_DEPTH);

    logic [15:0] wr_out [NUM_ID];
    logic [15:0] rd_out [NUM_ID];

    // Track outstanding requests per ID from port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ID; i++) begin
                wr_out[i] <= '0;
                rd_out[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ID; i++) begin
                wr_out[i] <= wr_out[i]
                    + 16'((s_aw_valid && s_aw_ready && s_aw_id == ID_W'(i)) ? 1 : 0)
                    - 16'((m_b_valid && s_b_ready && m_b_id == ID_W'(i)) ? 1 : 0);
                rd_out[i] <= rd_out[i]
                    + 16'((s_ar_valid && s_ar_ready && s_ar_id == ID_W'(i)) ? 1 : 0)
                    - 16'((m_r_valid && s_r_ready && m_r_last && m_r_id == ID_W'(i)) ? 1 : 0);
            end
        end
    end

    assert_aw_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_aw_valid && s_aw_ready) |-> (m_aw_valid && m_aw_ready));
    assert_ar_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && s_ar_ready) |-> (m_ar_valid && m_ar_ready));
    assert_aw_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_aw_valid && wr_out[s_aw_id] == 16'(DEPTH)) |-> (!s_aw_ready && !m_aw_valid));
    assert_ar_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && rd_out[s_ar_id] == 16'(DEPTH)) |-> (!s_ar_ready && !m_ar_valid));
    assert_aw_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_aw_valid && m_aw_ready && wr_out[s_aw_id] < 16'(DEPTH)) |-> s_aw_ready);
    assert_ar_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && m_ar_ready && rd_out[s_ar_id] < 16'(DEPTH)) |-> s_ar_ready);

    for (genvar g = 0; g < NUM_ID; g++) begin : g_cap
        assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_out[g] <= 16'(DEPTH)) && (rd_out[g] <= 16'(DEPTH)));
    end
endmodule

bind axi_user_strip axi_user_strip_chk #(
    .ID_W       (ID_W),
    .FLIGHT_CAP (FLIGHT_CAP),
    .MAX_DEPTH  (MAX_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_aw_valid (s_aw_valid),
    .s_aw_ready (s_aw_ready),
    .s_aw_id    (s_aw_id),
    .m_aw_valid (m_aw_valid),
    .m_aw_ready (m_aw_ready),
    .s_ar_valid (s_ar_valid),
    .s_ar_ready (s_ar_ready),
    .s_ar_id    (s_ar_id),
    .m_ar_valid (m_ar_valid),
    .m_ar_ready (m_ar_ready),
    .m_b_valid  (m_b_valid),
    .s_b_ready  (s_b_ready),
    .m_b_id     (m_b_id),
    .m_r_valid  (m_r_valid),
    .s_r_ready  (s_r_ready),
    .m_r_last   (m_r_last),
    .m_r_id     (m_r_id)
);

// File: tb/axi_user_strip_bench.sv
`timescale 1ns/1ps
module axi_user_strip_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       s_aw_valid, s_aw_ready, m_aw_valid, m_aw_ready;
    logic [1:0] s_aw_id, m_aw_id;
    logic [7:0] s_aw_addr, m_aw_addr;
    logic [3:0] s_aw_user;
    logic       s_w_valid, s_w_ready, s_w_last, m_w_valid, m_w_ready, m_w_last;
    logic [7:0] s_w_data, m_w_data;
    logic       m_b_valid, m_b_ready, s_b_valid, s_b_ready;
    logic [1:0] m_b_id, s_b_id, m_b_resp, s_b_resp;
    logic [3:0] s_b_user;
    logic       s_ar_valid, s_ar_ready, m_ar_valid, m_ar_ready;
    logic [1:0] s_ar_id, m_ar_id;
    logic [7:0] s_ar_addr, m_ar_addr;
    logic [3:0] s_ar_user;
    logic       m_r_valid, m_r_ready, m_r_last, s_r_valid, s_r_ready, s_r_last;
    logic [1:0] m_r_id, s_r_id, m_r_resp, s_r_resp;
    logic [7:0] m_r_data, s_r_data;
    logic [3:0] s_r_user;

    // Outputs of the default-cap instance.
    logic       d_s_aw_ready, d_m_aw_valid, d_s_w_ready, d_m_w_valid, d_m_w_last;
    logic [1:0] d_m_aw_id;
    logic [7:0] d_m_aw_addr, d_m_w_data;
    logic       d_m_b_ready, d_s_b_valid;
    logic [1:0] d_s_b_id, d_s_b_resp;
    logic [3:0] d_s_b_user;
    logic       d_s_ar_ready, d_m_ar_valid;
    logic [1:0] d_m_ar_id;
    logic [7:0] d_m_ar_addr;
    logic       d_m_r_ready, d_s_r_valid, d_s_r_last;
    logic [1:0] d_s_r_id, d_s_r_resp;
    logic [7:0] d_s_r_data;
    logic [3:0] d_s_r_user;

    axi_user_strip #(.FLIGHT_CAP(2), .MAX_DEPTH(4)) u_axi_user_strip (
        .clk(clk), .rst_n(rst_n),
        .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_id(s_aw_id),
        .s_aw_addr(s_aw_addr), .s_aw_user(s_aw_user),
        .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(m_aw_id), .m_aw_addr(m_aw_addr),
        .s_w_valid(s_w_valid), .s_w_ready(s_w_ready), .s_w_data(s_w_data), .s_w_last(s_w_last),
        .m_w_valid(m_w_valid), .m_w_ready(m_w_ready), .m_w_data(m_w_data), .m_w_last(m_w_last),
        .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_id(m_b_id), .m_b_resp(m_b_resp),
        .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id), .s_b_resp(s_b_resp),
        .s_b_user(s_b_user),
        .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_id(s_ar_id),
        .s_ar_addr(s_ar_addr), .s_ar_user(s_ar_user),
        .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_id(m_ar_id), .m_ar_addr(m_ar_addr),
        .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_id(m_r_id), .m_r_data(m_r_data),
        .m_r_resp(m_r_resp), .m_r_last(m_r_last),
        .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id), .s_r_data(s_r_data),
        .s_r_resp(s_r_resp), .s_r_last(s_r_last), .s_r_user(s_r_user)
    );

    axi_user_strip #(.FLIGHT_CAP(0), .MAX_DEPTH(3)) u_axi_user_strip_dflt (
        .clk(clk), .rst_n(rst_n),
        .s_aw_valid(s_aw_valid), .s_aw_ready(d_s_aw_ready), .s_aw_id(s_aw_id),
        .s_aw_addr(s_aw_addr), .s_aw_user(s_aw_user),
        .m_aw_valid(d_m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(d_m_aw_id), .m_aw_addr(d_m_aw_addr),
        .s_w_valid(s_w_valid), .s_w_ready(d_s_w_ready), .s_w_data(s_w_data), .s_w_last(s_w_last),
        .m_w_valid(d_m_w_valid), .m_w_ready(m_w_ready), .m_w_data(d_m_w_data), .m_w_last(d_m_w_last),
        .m_b_valid(m_b_valid), .m_b_ready(d_m_b_ready), .m_b_id(m_b_id), .m_b_resp(m_b_resp),
        .s_b_valid(d_s_b_valid), .s_b_ready(s_b_ready), .s_b_id(d_s_b_id), .s_b_resp(d_s_b_resp),
        .s_b_user(d_s_b_user),
        .s_ar_valid(s_ar_valid), .s_ar_ready(d_s_ar_ready), .s_ar_id(s_ar_id),
        .s_ar_addr(s_ar_addr), .s_ar_user(s_ar_user),
        .m_ar_valid(d_m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_id(d_m_ar_id), .m_ar_addr(d_m_ar_addr),
        .m_r_valid(m_r_valid), .m_r_ready(d_m_r_ready), .m_r_id(m_r_id), .m_r_data(m_r_data),
        .m_r_resp(m_r_resp), .m_r_last(m_r_last),
        .s_r_valid(d_s_r_valid), .s_r_ready(s_r_ready), .s_r_id(d_s_r_id), .s_r_data(d_s_r_data),
        .s_r_resp(d_s_r_resp), .s_r_last(d_s_r_last), .s_r_user(d_s_r_user)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] wq [4][$];
    logic [3:0] rq [4][$];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        s_aw_valid = 0; s_aw_id = 0; s_aw_addr = 0; s_aw_user = 0;
        s_ar_valid = 0; s_ar_id = 0; s_ar_addr = 0; s_ar_user = 0;
        s_w_valid = 0; s_w_data = 0; s_w_last = 0;
        m_b_valid = 0; m_b_id = 0; m_b_resp = 0;
        m_r_valid = 0; m_r_id = 0; m_r_data = 0; m_r_resp = 0; m_r_last = 0;
        m_aw_ready = 1; m_ar_ready = 1; m_w_ready = 1; s_b_ready = 1; s_r_ready = 1;
    endtask

    // Offer one write request for a clock edge; ok says whether it must pass.
    task automatic send_aw(input int id, input int addr, input int user, input bit ok);
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = 2'(id); s_aw_addr = 8'(addr); s_aw_user = 4'(user);
        #1;
        check(ok ? "R2 aw ready" : "R6 aw stall ready", int'(s_aw_ready), int'(ok));
        check(ok ? "R2 aw valid" : "R6 aw stall valid", int'(m_aw_valid), int'(ok));
        if (ok) begin
            check("R2 aw id", int'(m_aw_id), id);
            check("R2 aw addr", int'(m_aw_addr), addr);
            wq[id].push_back(4'(user));
        end
        @(posedge clk); #1;
        s_aw_valid = 0;
    endtask

    task automatic send_ar(input int id, input int addr, input int user, input bit ok);
        @(negedge clk);
        s_ar_valid = 1; s_ar_id = 2'(id); s_ar_addr = 8'(addr); s_ar_user = 4'(user);
        #1;
        check(ok ? "R9 ar ready" : "R6 ar stall ready", int'(s_ar_ready), int'(ok));
        check(ok ? "R2 ar valid" : "R6 ar stall valid", int'(m_ar_valid), int'(ok));
        if (ok) begin
            check("R2 ar id", int'(m_ar_id), id);
            check("R2 ar addr", int'(m_ar_addr), addr);
            rq[id].push_back(4'(user));
        end
        @(posedge clk); #1;
        s_ar_valid = 0;
    endtask

    task automatic send_b(input int id, input int resp, input bit rdy);
        @(negedge clk);
        m_b_valid = 1; m_b_id = 2'(id); m_b_resp = 2'(resp); s_b_ready = rdy;
        #1;
        check("R3 b user", int'(s_b_user), int'(wq[id][0]));
        check("R8 b resp", int'(s_b_resp), resp);
        check("R8 b id", int'(s_b_id), id);
        check("R8 b ready", int'(m_b_ready), int'(rdy));
        @(posedge clk); #1;
        m_b_valid = 0; s_b_ready = 1;
        if (rdy) void'(wq[id].pop_front());
    endtask

    task automatic send_r(input int id, input int data, input bit last);
        @(negedge clk);
        m_r_valid = 1; m_r_id = 2'(id); m_r_data = 8'(data); m_r_last = last;
        m_r_resp = 2'(id);
        #1;
        check(last ? "R4 r user last" : "R5 r user mid", int'(s_r_user), int'(rq[id][0]));
        check("R8 r data", int'(s_r_data), data);
        check("R8 r last", int'(s_r_last), int'(last));
        check("R8 r resp", int'(s_r_resp), id);
        @(posedge clk); #1;
        m_r_valid = 0; m_r_last = 0;
        if (last) void'(rq[id].pop_front());
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        int b_order [8] = '{2, 0, 3, 1, 0, 2, 1, 3};
        int r_id [12]   = '{3, 1, 3, 0, 2, 2, 1, 1, 3, 0, 0, 2};
        int r_last [12] = '{0, 1, 1, 1, 0, 1, 0, 1, 1, 0, 1, 1};
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R1 aw ready", int'(s_aw_ready), 1);
        check("R1 aw valid", int'(m_aw_valid), 0);
        check("R1 ar ready", int'(s_ar_ready), 1);
        check("R1 ar valid", int'(m_ar_valid), 0);

        // W passthrough, including back-pressure.
        @(negedge clk);
        s_w_valid = 1; s_w_data = 8'hA5; s_w_last = 1; m_w_ready = 0;
        #1;
        check("R8 w valid", int'(m_w_valid), 1);
        check("R8 w data", int'(m_w_data), 8'hA5);
        check("R8 w last", int'(m_w_last), 1);
        check("R8 w ready", int'(s_w_ready), 0);
        idle();

        // Fill every write queue.
        for (int n = 0; n < 2; n++)
            for (int id = 0; id < 4; id++)
                send_aw(id, id * 16 + n, (id * 3 + n * 5 + 2) & 15, 1);
        // Each ID is now at its cap; the default-cap instance takes one more.
        for (int id = 0; id < 4; id++)
            send_aw(id, 8'hF0, 4'hF, 0);
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = 2'd1;
        #1;
        check("R10 dflt stall ready", int'(d_s_aw_ready), 0);
        check("R10 dflt stall valid", int'(d_m_aw_valid), 0);
        s_aw_valid = 0;

        // Reads proceed with writes full, then fill.
        for (int n = 0; n < 2; n++)
            for (int id = 0; id < 4; id++)
                send_ar(id, 8'h80 + id * 16 + n, (id * 7 + n * 2 + 9) & 15, 1);
        for (int id = 0; id < 4; id++)
            send_ar(id, 8'hE0, 4'h0, 0);

        // B held by upstream: nothing freed.
        send_b(2, 1, 0);
        @(negedge clk);
        s_aw_valid = 1; s_aw_id = 2'd2;
        #1;
        check("R7 held b frees nothing", int'(s_aw_ready), 0);
        s_aw_valid = 0;

        // Out-of-order B responses.
        for (int k = 0; k < 8; k++) begin
            send_b(b_order[k], (b_order[k] + k) & 3, 1);
            if (k == 0) begin
                @(negedge clk);
                s_aw_valid = 1; s_aw_id = 2'd2;
                #1;
                check("R7 b frees slot", int'(s_aw_ready), 1);
                s_aw_valid = 0;
            end
        end

        // Interleaved R bursts.
        for (int k = 0; k < 12; k++) begin
            send_r(r_id[k], r_id[k] * 17 + k, r_last[k] != 0);
            if (k == 0) begin
                @(negedge clk);
                s_ar_valid = 1; s_ar_id = 2'd3;
                #1;
                check("R5 mid beat keeps entry", int'(s_ar_ready), 0);
                s_ar_valid = 0;
            end
        end
        @(negedge clk);
        s_ar_valid = 1; s_ar_id = 2'd0;
        #1;
        check("R7 r last frees slot", int'(s_ar_ready), 1);
        idle();

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end
endmodule